// File: doc/BRIEF.md
# Transmit Packet-Interface Flow Control Unit

This unit sits beside a transmit packet buffer and tells the upstream bus master whether it may push more data. It compares the buffer fill level, counted in 32-bit words, against two programmable limits. The request output drops once the level rises above the upper limit, and it returns once the level falls below the lower limit. Between the two limits the request keeps its last value, so a level that hovers near one limit does not make the request toggle.

The same unit checks odd parity on every accepted transmit word and records three events in sticky status bits: the buffer becoming full, a parity error, and an external error pin being high. Each status bit has an enable bit. The interrupt output is high while any enabled status bit is set. Software clears a status bit by writing 1 to it.

Two state machines carry the sequential behaviour. The request machine has state REQ_ON, which is entered at reset and drives the request high, and state REQ_OFF, which drives it low. Transition DROP goes from REQ_ON to REQ_OFF when fill > upper limit. Transition RAISE goes from REQ_OFF to REQ_ON when fill < lower limit. Every other case is HOLD. The full-detect machine has states FD_BELOW and FD_FULL. Transition ENTER (FD_BELOW to FD_FULL, when fill reaches the buffer depth) emits one full event. Transition LEAVE (FD_FULL to FD_BELOW) occurs when the level drops below the depth.

Top module: `pfc_top`

## Requirements
- R1: After reset, pkt_req is 1. The threshold register reads 0x0180_0080, which is an upper limit of 384 and a lower limit of 128. The control register reads 0, so all interrupt enables are clear and parity checking is on. The status register reads 0, and irq is 0.
- R2: If fill_words is greater than the upper limit while pkt_req is 1, pkt_req is 0 after the next clock edge.
- R3: If fill_words is less than the lower limit while pkt_req is 0, pkt_req is 1 after the next clock edge.
- R4: If fill_words lies between the lower and upper limits, both limits included, pkt_req keeps its value across the next clock edge.
- R5: The register map has three addresses:
  - Address 0 is the threshold register. The upper limit is in bits 24:16 and the lower limit is in bits 8:0.
  - Address 1 is the control register. Bit 31 disables parity checking, bit 2 enables the full interrupt, bit 1 enables the parity interrupt, and bit 0 enables the error-pin interrupt.
  - Address 2 is the status register, with the full event in bit 2, the parity event in bit 1 and the error-pin event in bit 0.
  - Bits not listed read 0.
- R6: When parity checking is enabled, a word accepted with tx_valid=1 whose 32 data bits plus tx_par hold an even number of ones sets status bit 1 at the next edge. A word with an odd count does not set it, and neither does a word presented with tx_valid=0.
- R7: While control bit 31 is 1, no word sets status bit 1.
- R8: Status bit 2 is set at the edge on which fill_words first reaches BUF_WORDS (512) from below. It is not set again while the level stays at or above 512.
- R9: Status bit 0 is set at every edge at which err_pin is 1.
- R10: Status bits are set regardless of their enables. They stay set until a write to address 2 has 1 in their position, and writing 0 leaves them unchanged. If an event and a clear hit the same bit at the same edge, the event wins.
- R11: irq is 1 exactly when some status bit and its matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_words | input | 10 | Buffer fill level in 32-bit words |
| tx_data | input | 32 | Transmit data word |
| tx_par | input | 1 | Parity bit for tx_data |
| tx_valid | input | 1 | tx_data and tx_par are accepted this cycle |
| err_pin | input | 1 | External error indication |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| pkt_req | output | 1 | Packet-available request to the bus master |
| irq | output | 1 | Interrupt |

## Verification
On every cycle the assertions check three things. The request machine must honour its DROP, RAISE and HOLD rules against the programmed limits. The full-detect machine must emit no more than one event per entry into the full condition. Every status bit must stay set until it is cleared and must be set after any event. Only the directed scenarios can show the rest: the exact register layout and reset values, the odd-parity convention, the effect of the parity disable bit, set winning over clear, and the irq masking. These depend on encodings that no single property in the design states independently.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int unsigned REG_AW = 2;
    localparam logic [REG_AW-1:0] ADDR_THR  = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CTL  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

    localparam int unsigned THR_HI_LSB = 16;
    localparam int unsigned THR_LO_LSB = 0;
    localparam int unsigned CTL_PDIS   = 31;

    localparam int unsigned EVT_N    = 3;
    localparam int unsigned EVT_ERR  = 0;
    localparam int unsigned EVT_PAR  = 1;
    localparam int unsigned EVT_FULL = 2;

    typedef enum logic [0:0] {
        REQ_ON  = 1'b0,
        REQ_OFF = 1'b1
    } req_state_t;

    typedef enum logic [0:0] {
        FD_BELOW = 1'b0,
        FD_FULL  = 1'b1
    } full_state_t;

endpackage

// File: rtl/pfc_req_fsm.sv
module pfc_req_fsm
    import pfc_pkg::*;
#(
    parameter int unsigned TH_W   = 9,
    parameter int unsigned FILL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [TH_W-1:0]   thr_hi,
    input  logic [TH_W-1:0]   thr_lo,
    output logic              req
);

    localparam int unsigned CW = (FILL_W > TH_W) ? FILL_W : TH_W;

    logic [CW-1:0] fill_x, hi_x, lo_x;
    logic          above_hi, below_lo;
    req_state_t    state_q, state_d;

    assign fill_x   = CW'(fill);
    assign hi_x     = CW'(thr_hi);
    assign lo_x     = CW'(thr_lo);
    assign above_hi = fill_x > hi_x;
    assign below_lo = fill_x < lo_x;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_ON:  if (above_hi) state_d = REQ_OFF;
            REQ_OFF: if (below_lo) state_d = REQ_ON;
            default: state_d = REQ_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        req = (state_q == REQ_ON);
    end

    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (fill_x > hi_x)) |=> !req);

    assert_req_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && (fill_x < lo_x)) |=> req);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_x >= lo_x) && (fill_x <= hi_x)) |=> $stable(req));

endmodule

// File: rtl/pfc_full_det.sv
module pfc_full_det
    import pfc_pkg::*;
#(
    parameter int unsigned FILL_W    = 10,
    parameter int unsigned BUF_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    output logic              full_evt
);

    logic        is_full;
    full_state_t state_q, state_d;

    assign is_full = (32'(fill) >= BUF_WORDS);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FD_BELOW: if (is_full)  state_d = FD_FULL;
            FD_FULL:  if (!is_full) state_d = FD_BELOW;
            default:  state_d = FD_BELOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FD_BELOW;
        else        state_q <= state_d;
    end

    always_comb begin
        full_evt = (state_q == FD_BELOW) && is_full;
    end

    assert_single_full_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |=> !full_evt);

endmodule

// File: rtl/pfc_parity.sv
module pfc_parity
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          valid,
    input  logic          check_off,
    output logic          perr
);

    logic ones_odd;

    assign ones_odd = ^{data, par};
    assign perr     = valid && !check_off && !ones_odd;

endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned TH_W     = 9,
    parameter logic [TH_W-1:0] HI_RST = 9'd384,
    parameter logic [TH_W-1:0] LO_RST = 9'd128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [REG_AW-1:0] raddr,
    input  logic [EVT_N-1:0]  evt,
    output logic [DW-1:0]     rdata,
    output logic [TH_W-1:0]   thr_hi,
    output logic [TH_W-1:0]   thr_lo,
    output logic              par_off,
    output logic              irq
);

    logic [EVT_N-1:0] en_q, stat_q, clr;
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_hi  <= HI_RST;
            thr_lo  <= LO_RST;
            par_off <= 1'b0;
            en_q    <= '0;
        end else if (wr) begin
            if (waddr == ADDR_THR) begin
                thr_hi <= wdata[THR_HI_LSB +: TH_W];
                thr_lo <= wdata[THR_LO_LSB +: TH_W];
            end
            if (waddr == ADDR_CTL) begin
                par_off <= wdata[CTL_PDIS];
                en_q    <= wdata[EVT_N-1:0];
            end
        end
    end

    assign clr = (wr && (waddr == ADDR_STAT)) ? wdata[EVT_N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    always_comb begin
        rdata = '0;
        unique case (raddr)
            ADDR_THR: begin
                rdata[THR_HI_LSB +: TH_W] = thr_hi;
                rdata[THR_LO_LSB +: TH_W] = thr_lo;
            end
            ADDR_CTL: begin
                rdata[CTL_PDIS]    = par_off;
                rdata[EVT_N-1:0]   = en_q;
            end
            ADDR_STAT: rdata[EVT_N-1:0] = stat_q;
            default:   rdata = '0;
        endcase
    end

    assign irq = |(stat_q & en_q);

    for (genvar i = 0; i < EVT_N; i++) begin : g_stat_chk
        assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr[i]) |=> stat_q[i]);
        assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat_q[i]);
    end

endmodule

// File: rtl/pfc_top.sv
module pfc_top
    import pfc_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned TH_W      = 9,
    parameter int unsigned BUF_WORDS = 512,
    parameter int unsigned FILL_W    = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill_words,
    input  logic [DW-1:0]     tx_data,
    input  logic              tx_par,
    input  logic              tx_valid,
    input  logic              err_pin,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [DW-1:0]     reg_rdata,
    output logic              pkt_req,
    output logic              irq
);

    logic [TH_W-1:0]  thr_hi, thr_lo;
    logic             par_off, perr, full_evt;
    logic [EVT_N-1:0] evt;

    pfc_regs #(.DW(DW), .TH_W(TH_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .evt(evt), .rdata(reg_rdata),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .par_off(par_off), .irq(irq)
    );

    pfc_req_fsm #(.TH_W(TH_W), .FILL_W(FILL_W)) u_req (
        .clk(clk), .rst_n(rst_n), .fill(fill_words),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .req(pkt_req)
    );

    pfc_full_det #(.FILL_W(FILL_W), .BUF_WORDS(BUF_WORDS)) u_full (
        .clk(clk), .rst_n(rst_n), .fill(fill_words), .full_evt(full_evt)
    );

    pfc_parity #(.DW(DW)) u_par (
        .data(tx_data), .par(tx_par), .valid(tx_valid),
        .check_off(par_off), .perr(perr)
    );

    always_comb begin
        evt           = '0;
        evt[EVT_ERR]  = err_pin;
        evt[EVT_PAR]  = perr;
        evt[EVT_FULL] = full_evt;
    end

endmodule

// File: tb/test_pfc_top.sv
module test_pfc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  fill_words = '0;
    logic [31:0] tx_data = '0;
    logic        tx_par = 1'b0;
    logic        tx_valid = 1'b0;
    logic        err_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        pkt_req, irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pfc_top i_pfc_top (
        .clk(clk), .rst_n(rst_n), .fill_words(fill_words),
        .tx_data(tx_data), .tx_par(tx_par), .tx_valid(tx_valid),
        .err_pin(err_pin), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .pkt_req(pkt_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 req", {31'b0, pkt_req}, 32'd1);
        rd(2'd0, v); chk("R1 thr", v, 32'h0180_0080);
        rd(2'd1, v); chk("R1 ctl", v, 32'h0);
        rd(2'd2, v); chk("R1 stat", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R5 thr reserved", v, 32'h01FF_01FF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R5 ctl reserved", v, 32'h8000_0007);
        wr(2'd1, 32'h0);
        wr(2'd0, {7'b0, 9'd100, 7'b0, 9'd20});
        rd(2'd0, v); chk("R5 thr fields", v, 32'h0064_0014);
    endtask

    task automatic t_hyst();
        fill_words = 10'd50; step();
        chk("R4 hold high mid", {31'b0, pkt_req}, 32'd1);
        fill_words = 10'd100; step();
        chk("R4 hold at upper", {31'b0, pkt_req}, 32'd1);
        fill_words = 10'd101; step();
        chk("R2 drop above upper", {31'b0, pkt_req}, 32'd0);
        fill_words = 10'd100; step();
        chk("R4 hold low at upper", {31'b0, pkt_req}, 32'd0);
        fill_words = 10'd20; step();
        chk("R4 hold low at lower", {31'b0, pkt_req}, 32'd0);
        fill_words = 10'd19; step();
        chk("R3 raise below lower", {31'b0, pkt_req}, 32'd1);
        fill_words = 10'd20; step();
        chk("R4 hold high at lower", {31'b0, pkt_req}, 32'd1);
    endtask

    task automatic t_parity();
        logic [31:0] v;
        tx_data = 32'h0000_0001; tx_par = 1'b0; tx_valid = 1'b1; step();
        rd(2'd2, v); chk("R6 good word", v, 32'h0);
        tx_par = 1'b1; tx_valid = 1'b0; step();
        rd(2'd2, v); chk("R6 invalid bad word", v, 32'h0);
        wr(2'd1, 32'h8000_0000);
        tx_valid = 1'b1; step();
        rd(2'd2, v); chk("R7 disabled", v, 32'h0);
        wr(2'd1, 32'h0);
        tx_data = 32'hF0F0_0000; tx_par = 1'b0; step();
        tx_valid = 1'b0;
        rd(2'd2, v); chk("R6 bad word", v, 32'h2);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R10 write 0 keeps", v, 32'h2);
        wr(2'd2, 32'h2);
        rd(2'd2, v); chk("R10 clear", v, 32'h0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        fill_words = 10'd511; step();
        rd(2'd2, v); chk("R8 not full", v, 32'h0);
        fill_words = 10'd512; step();
        rd(2'd2, v); chk("R8 became full", v, 32'h4);
        wr(2'd2, 32'h4);
        step();
        rd(2'd2, v); chk("R8 stays full no reset", v, 32'h0);
        fill_words = 10'd0; step();
        fill_words = 10'd512; step();
        rd(2'd2, v); chk("R8 second entry", v, 32'h4);
        fill_words = 10'd0;
        wr(2'd2, 32'h4);
    endtask

    task automatic t_errpin();
        logic [31:0] v;
        err_pin = 1'b1; step();
        rd(2'd2, v); chk("R9 pin set", v, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk("R10 set beats clear", v, 32'h1);
        err_pin = 1'b0;
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk("R9 cleared", v, 32'h0);
    endtask

    task automatic t_irq();
        wr(2'd1, 32'h2);
        err_pin = 1'b1; step(); err_pin = 1'b0;
        chk("R11 masked", {31'b0, irq}, 32'd0);
        tx_data = 32'h0; tx_par = 1'b0; tx_valid = 1'b1; step();
        tx_valid = 1'b0;
        chk("R11 enabled", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'h2);
        chk("R11 after clear", {31'b0, irq}, 32'd0);
        wr(2'd1, 32'h1);
        chk("R11 other enable", {31'b0, irq}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_hyst();
        t_parity();
        t_full();
        t_errpin();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule